// File: doc/BRIEF.md
# Workgroup Admission Checker

This block decides whether a new workgroup fits on a compute unit at this moment. It multiplies the three workgroup dimensions to get the work-item count and rounds that up to a whole number of waves. It then places those waves on free wave slots, scanning the SIMD units from index 0 upward. For that placement it checks that every SIMD has enough free vector and scalar registers. It also checks that the local data store has room, and that a barrier slot is free when the workgroup spans more than one wave.

The outputs are one admit flag and one blocked flag for each resource shortage, so that a dispatcher can count why workgroups stall. The waves needed and the waves actually placed are also brought out. The block only gives the verdict: reserving the resources is the caller's job. Every pin is a plain level. Each decision follows its inputs by a fixed two-cycle latency, with no handshake and no back-pressure.

Top module: `wg_admit_check`

## Requirements
- R1: The work-item count is the product of `wg_dim_x`, `wg_dim_y` and `wg_dim_z`. A zero in any dimension gives zero work-items and zero waves.
- R2: `waves_needed` is the work-item count divided by WAVE_SIZE (default 64), rounded up.
- R3: Waves are placed greedily. SIMD 0 takes as many waves as its free-slot count allows (`simd_free_slots` bits [4i+3:4i] belong to SIMD i), then SIMD 1 takes from what is left, and so on. `waves_mapped` is the total placed and never exceeds `waves_needed`.
- R4: SIMD i lacks vector registers when its free count (`simd_free_vregs` bits [12i+11:12i]) is below the waves placed on it times `vreg_per_wave`. `blk_vreg` is 1 when any SIMD lacks them.
- R5: The scalar check works the same way on `simd_free_sregs` (bits [10i+9:10i]) and `sreg_per_wave`. A failure drives `blk_sreg`.
- R6: `blk_lds` is 1 exactly when `lds_bytes_req` exceeds `lds_bytes_free`. An equal value fits.
- R7: `blk_barrier` is 1 exactly when more than one wave is needed and `barrier_free` is 0. A workgroup of one wave or less ignores `barrier_free`.
- R8: `admit` is 1 only when `waves_mapped` equals `waves_needed` and none of the four blocked flags is set. A slot shortfall alone clears `admit` and sets no blocked flag.
- R9: All outputs are registered. They read 0 during reset and reflect an input set two rising edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wg_dim_x | input | DIM_W | Workgroup size, first dimension |
| wg_dim_y | input | DIM_W | Workgroup size, second dimension |
| wg_dim_z | input | DIM_W | Workgroup size, third dimension |
| vreg_per_wave | input | VDEM_W | Vector registers needed by each wave |
| sreg_per_wave | input | SDEM_W | Scalar registers needed by each wave |
| lds_bytes_req | input | LDS_W | Local data store bytes the workgroup needs |
| lds_bytes_free | input | LDS_W | Local data store bytes free |
| barrier_free | input | 1 | A barrier slot is available |
| simd_free_slots | input | NUM_SIMD*SLOT_W | Free wave slots, one field per SIMD |
| simd_free_vregs | input | NUM_SIMD*VREG_W | Free vector registers, one field per SIMD |
| simd_free_sregs | input | NUM_SIMD*SREG_W | Free scalar registers, one field per SIMD |
| admit | output | 1 | Workgroup may be dispatched |
| waves_needed | output | WAVE_W | Waves the workgroup needs |
| waves_mapped | output | WAVE_W | Waves placed on free slots |
| blk_vreg | output | 1 | Blocked by vector registers |
| blk_sreg | output | 1 | Blocked by scalar registers |
| blk_lds | output | 1 | Blocked by local data store space |
| blk_barrier | output | 1 | Blocked by barrier slot shortage |

## Verification
The inputs are captured on the first rising edge after they change, and the verdict is registered on the second. Every output therefore moves exactly two edges after a new input set. The bench drives each input set on a falling edge, lets two rising edges pass, and samples on the falling edge that follows. It never reads a result earlier than its due cycle or reads a stale value after it. The clocked properties check the same one-edge step between the captured inputs and the registered verdict.

// File: rtl/wg_admit_pkg.sv
package wg_admit_pkg;
  typedef struct packed {
    logic slots_ok;
    logic vreg_ok;
    logic sreg_ok;
    logic lds_ok;
    logic bar_ok;
  } verdict_t;
endpackage

// File: rtl/wg_wave_count.sv
module wg_wave_count #(
  parameter int DIM_W     = 10,
  parameter int WAVE_SIZE = 64,
  localparam int LOG_WS   = $clog2(WAVE_SIZE),
  localparam int TOT_W    = 3 * DIM_W,
  localparam int WAVE_W   = TOT_W + 1 - LOG_WS
) (
  input  logic [DIM_W-1:0]  dim_x,
  input  logic [DIM_W-1:0]  dim_y,
  input  logic [DIM_W-1:0]  dim_z,
  output logic [WAVE_W-1:0] waves
);
  localparam logic [TOT_W:0] ROUND = (TOT_W+1)'(WAVE_SIZE - 1);
  logic [TOT_W-1:0] items;
  logic [TOT_W:0]   padded;

  // Item count of the workgroup, then ceiling division by a power of two.
  assign items  = TOT_W'(dim_x) * TOT_W'(dim_y) * TOT_W'(dim_z);
  assign padded = {1'b0, items} + ROUND;
  assign waves  = padded[TOT_W:LOG_WS];
endmodule

// File: rtl/wg_slot_mapper.sv
module wg_slot_mapper #(
  parameter int NUM_SIMD = 4,
  parameter int SLOT_W   = 4,
  parameter int WAVE_W   = 25
) (
  input  logic [WAVE_W-1:0]          need,
  input  logic [NUM_SIMD*SLOT_W-1:0] free_slots,
  output logic [NUM_SIMD*SLOT_W-1:0] take,
  output logic [WAVE_W-1:0]          mapped
);
  logic [WAVE_W-1:0] acc [NUM_SIMD+1];
  assign acc[0] = '0;

  // Greedy chain: each SIMD fills from what lower-index SIMDs left over.
  for (genvar i = 0; i < NUM_SIMD; i++) begin : g_simd
    logic [WAVE_W-1:0] left;
    logic [WAVE_W-1:0] slot_ext;
    logic [SLOT_W-1:0] take_i;
    assign left     = need - acc[i];
    assign slot_ext = WAVE_W'(free_slots[i*SLOT_W +: SLOT_W]);
    assign take_i   = (slot_ext < left) ? free_slots[i*SLOT_W +: SLOT_W]
                                        : left[SLOT_W-1:0];
    assign take[i*SLOT_W +: SLOT_W] = take_i;
    assign acc[i+1] = acc[i] + WAVE_W'(take_i);
  end

  assign mapped = acc[NUM_SIMD];
endmodule

// File: rtl/wg_reg_check.sv
module wg_reg_check #(
  parameter int NUM_SIMD = 4,
  parameter int SLOT_W   = 4,
  parameter int DEM_W    = 8,
  parameter int FREE_W   = 12
) (
  input  logic [NUM_SIMD*SLOT_W-1:0] take,
  input  logic [DEM_W-1:0]           per_wave,
  input  logic [NUM_SIMD*FREE_W-1:0] free_regs,
  output logic                       all_ok
);
  localparam int PW = SLOT_W + DEM_W;
  localparam int CW = (PW > FREE_W) ? PW : FREE_W;
  logic [NUM_SIMD-1:0] ok;

  for (genvar i = 0; i < NUM_SIMD; i++) begin : g_simd
    logic [PW-1:0] demand_i;
    assign demand_i = PW'(take[i*SLOT_W +: SLOT_W]) * PW'(per_wave);
    assign ok[i]    = CW'(free_regs[i*FREE_W +: FREE_W]) >= CW'(demand_i);
  end

  assign all_ok = &ok;
endmodule

// File: rtl/wg_admit_check.sv
module wg_admit_check
  import wg_admit_pkg::*;
#(
  parameter int NUM_SIMD  = 4,
  parameter int WAVE_SIZE = 64,
  parameter int DIM_W     = 10,
  parameter int SLOT_W    = 4,
  parameter int VDEM_W    = 8,
  parameter int VREG_W    = 12,
  parameter int SDEM_W    = 7,
  parameter int SREG_W    = 10,
  parameter int LDS_W     = 17,
  localparam int WAVE_W   = 3 * DIM_W + 1 - $clog2(WAVE_SIZE)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DIM_W-1:0]           wg_dim_x,
  input  logic [DIM_W-1:0]           wg_dim_y,
  input  logic [DIM_W-1:0]           wg_dim_z,
  input  logic [VDEM_W-1:0]          vreg_per_wave,
  input  logic [SDEM_W-1:0]          sreg_per_wave,
  input  logic [LDS_W-1:0]           lds_bytes_req,
  input  logic [LDS_W-1:0]           lds_bytes_free,
  input  logic                       barrier_free,
  input  logic [NUM_SIMD*SLOT_W-1:0] simd_free_slots,
  input  logic [NUM_SIMD*VREG_W-1:0] simd_free_vregs,
  input  logic [NUM_SIMD*SREG_W-1:0] simd_free_sregs,
  output logic                       admit,
  output logic [WAVE_W-1:0]          waves_needed,
  output logic [WAVE_W-1:0]          waves_mapped,
  output logic                       blk_vreg,
  output logic                       blk_sreg,
  output logic                       blk_lds,
  output logic                       blk_barrier
);
  // Stage 1: captured request.
  logic [DIM_W-1:0]           dx_q, dy_q, dz_q;
  logic [VDEM_W-1:0]          vdem_q;
  logic [SDEM_W-1:0]          sdem_q;
  logic [LDS_W-1:0]           lreq_q, lfree_q;
  logic                       bar_q;
  logic [NUM_SIMD*SLOT_W-1:0] slots_q;
  logic [NUM_SIMD*VREG_W-1:0] vfree_q;
  logic [NUM_SIMD*SREG_W-1:0] sfree_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dx_q <= '0; dy_q <= '0; dz_q <= '0;
      vdem_q <= '0; sdem_q <= '0;
      lreq_q <= '0; lfree_q <= '0; bar_q <= 1'b0;
      slots_q <= '0; vfree_q <= '0; sfree_q <= '0;
    end else begin
      dx_q <= wg_dim_x; dy_q <= wg_dim_y; dz_q <= wg_dim_z;
      vdem_q <= vreg_per_wave; sdem_q <= sreg_per_wave;
      lreq_q <= lds_bytes_req; lfree_q <= lds_bytes_free; bar_q <= barrier_free;
      slots_q <= simd_free_slots; vfree_q <= simd_free_vregs; sfree_q <= simd_free_sregs;
    end
  end

  // Combinational decision.
  logic [WAVE_W-1:0]          waves_w, mapped_w;
  logic [NUM_SIMD*SLOT_W-1:0] take_w;
  logic                       vok_w, sok_w;
  verdict_t                   vd;

  wg_wave_count #(.DIM_W(DIM_W), .WAVE_SIZE(WAVE_SIZE)) u_count (
    .dim_x(dx_q), .dim_y(dy_q), .dim_z(dz_q), .waves(waves_w)
  );

  wg_slot_mapper #(.NUM_SIMD(NUM_SIMD), .SLOT_W(SLOT_W), .WAVE_W(WAVE_W)) u_map (
    .need(waves_w), .free_slots(slots_q), .take(take_w), .mapped(mapped_w)
  );

  wg_reg_check #(.NUM_SIMD(NUM_SIMD), .SLOT_W(SLOT_W), .DEM_W(VDEM_W),
                 .FREE_W(VREG_W)) u_vchk (
    .take(take_w), .per_wave(vdem_q), .free_regs(vfree_q), .all_ok(vok_w)
  );

  wg_reg_check #(.NUM_SIMD(NUM_SIMD), .SLOT_W(SLOT_W), .DEM_W(SDEM_W),
                 .FREE_W(SREG_W)) u_schk (
    .take(take_w), .per_wave(sdem_q), .free_regs(sfree_q), .all_ok(sok_w)
  );

  always_comb begin
    vd.slots_ok = (mapped_w == waves_w);
    vd.vreg_ok  = vok_w;
    vd.sreg_ok  = sok_w;
    vd.lds_ok   = (lreq_q <= lfree_q);
    vd.bar_ok   = (waves_w <= WAVE_W'(1)) || bar_q;
  end

  // Stage 2: registered verdict.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      admit <= 1'b0; waves_needed <= '0; waves_mapped <= '0;
      blk_vreg <= 1'b0; blk_sreg <= 1'b0; blk_lds <= 1'b0; blk_barrier <= 1'b0;
    end else begin
      admit        <= &vd;
      waves_needed <= waves_w;
      waves_mapped <= mapped_w;
      blk_vreg     <= !vd.vreg_ok;
      blk_sreg     <= !vd.sreg_ok;
      blk_lds      <= !vd.lds_ok;
      blk_barrier  <= !vd.bar_ok;
    end
  end

  // Placement from the mapper never outruns the counter's demand.
  assert_map_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mapped_w <= waves_w);

  assert_admit_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    admit |-> (!blk_vreg && !blk_sreg && !blk_lds && !blk_barrier
               && waves_mapped == waves_needed));

  assert_lone_wave_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (waves_w <= WAVE_W'(1)) |=> !blk_barrier);

  assert_lds_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lreq_q > lfree_q) |=> (blk_lds && !admit));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (waves_needed == $past(waves_w)));
endmodule

// File: tb/wg_admit_check_bench.sv
module wg_admit_check_bench;
  localparam int NS = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0]  dx, dy, dz;
  logic [7:0]  vdem;
  logic [6:0]  sdem;
  logic [16:0] lreq, lfree;
  logic        bar;
  logic [15:0] slots;
  logic [47:0] vfree;
  logic [39:0] sfree;
  logic        admit, blk_vreg, blk_sreg, blk_lds, blk_barrier;
  logic [24:0] waves_needed, waves_mapped;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wg_admit_check u_wg_admit_check (
    .clk(clk), .rst_n(rst_n),
    .wg_dim_x(dx), .wg_dim_y(dy), .wg_dim_z(dz),
    .vreg_per_wave(vdem), .sreg_per_wave(sdem),
    .lds_bytes_req(lreq), .lds_bytes_free(lfree), .barrier_free(bar),
    .simd_free_slots(slots), .simd_free_vregs(vfree), .simd_free_sregs(sfree),
    .admit(admit), .waves_needed(waves_needed), .waves_mapped(waves_mapped),
    .blk_vreg(blk_vreg), .blk_sreg(blk_sreg), .blk_lds(blk_lds),
    .blk_barrier(blk_barrier)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic defaults();
    dx = 10'd1; dy = 10'd1; dz = 10'd1;
    vdem = 8'd8; sdem = 7'd4; lreq = 17'd100; lfree = 17'd1000; bar = 1'b1;
    slots = {NS{4'd4}}; vfree = {NS{12'd1000}}; sfree = {NS{10'd500}};
  endtask

  // Apply on a falling edge, let two rising edges pass, sample on the next fall.
  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 reset admit", int'(admit), 0);
    chk("R9 reset waves", int'(waves_needed), 0);
    chk("R9 reset blk", int'({blk_vreg, blk_sreg, blk_lds, blk_barrier}), 0);
  endtask

  task automatic t_basic();
    defaults(); dx = 10'd8; dy = 10'd8; dz = 10'd2;
    settle();
    chk("R1 8x8x2 waves", int'(waves_needed), 2);
    chk("R8 basic admit", int'(admit), 1);
    chk("R3 basic mapped", int'(waves_mapped), 2);
  endtask

  task automatic t_round();
    defaults(); dx = 10'd65;
    settle(); chk("R2 65 items", int'(waves_needed), 2);
    dx = 10'd64;
    settle(); chk("R2 64 items", int'(waves_needed), 1);
    dx = 10'd3; dy = 10'd5; dz = 10'd7;
    settle(); chk("R2 105 items", int'(waves_needed), 2);
    dx = 10'd0;
    settle();
    chk("R1 zero dim waves", int'(waves_needed), 0);
    chk("R1 zero dim admit", int'(admit), 1);
  endtask

  task automatic t_greedy();
    defaults(); dx = 10'd192; vdem = 8'd10;
    slots = {4'd5, 4'd5, 4'd0, 4'd2};
    vfree = {12'd0, 12'd9, 12'd0, 12'd20};
    settle();
    chk("R3 greedy mapped", int'(waves_mapped), 3);
    chk("R4 simd2 short", int'(blk_vreg), 1);
    chk("R4 blocked admit", int'(admit), 0);
    vfree = {12'd0, 12'd10, 12'd0, 12'd20};
    settle();
    chk("R4 exact fit", int'(blk_vreg), 0);
    chk("R3 greedy admit", int'(admit), 1);
  endtask

  task automatic t_slots();
    defaults(); dx = 10'd256; slots = {4'd0, 4'd1, 4'd1, 4'd1};
    settle();
    chk("R3 short mapped", int'(waves_mapped), 3);
    chk("R8 slot short admit", int'(admit), 0);
    chk("R8 no blk flags", int'({blk_vreg, blk_sreg, blk_lds, blk_barrier}), 0);
  endtask

  task automatic t_sreg();
    defaults(); dx = 10'd128; sdem = 7'd20; slots = {4'd0, 4'd0, 4'd0, 4'd4};
    sfree = {10'd500, 10'd500, 10'd500, 10'd39};
    settle();
    chk("R5 sreg short", int'(blk_sreg), 1);
    chk("R5 vreg unaffected", int'(blk_vreg), 0);
    sfree = {10'd0, 10'd0, 10'd0, 10'd40};
    settle();
    chk("R5 sreg fit", int'(blk_sreg), 0);
    chk("R5 admit", int'(admit), 1);
  endtask

  task automatic t_lds();
    defaults(); lreq = 17'd1000;
    settle(); chk("R6 equal fits", int'(blk_lds), 0);
    lreq = 17'd1001;
    settle();
    chk("R6 over", int'(blk_lds), 1);
    chk("R6 admit", int'(admit), 0);
  endtask

  task automatic t_barrier();
    defaults(); dx = 10'd64; bar = 1'b0;
    settle();
    chk("R7 one wave ignores", int'(blk_barrier), 0);
    chk("R7 one wave admit", int'(admit), 1);
    dx = 10'd65;
    settle();
    chk("R7 two waves blocked", int'(blk_barrier), 1);
    chk("R7 two waves admit", int'(admit), 0);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic(); t_round(); t_greedy(); t_slots(); t_sreg(); t_lds(); t_barrier();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule